// File: doc/BRIEF.md
# Receive FIFO Status Calendar Sequencer

This block produces the 2-bit receive-side FIFO status stream of a SPI-4.2 style packet interface. A calendar of port numbers decides which port's status goes out in each status cycle. Software loads the calendar, the walk length, the repeat count, the port limit, the enables and a per-port ignore mask through a small register port. The block reads per-port fill hints from the receive buffers and turns them into STARVING, HUNGRY or SATISFIED words. Each round opens with a framing word and closes with a parity word.

Calendar words are protected by odd parity. While the interface is enabled the calendar cannot be read or written. A port whose ignore bit is set always reports STARVING, so the far end never receives backpressure for that port.

Top module: `rx_stat_seq`

## Requirements
- R1: After reset, `stat_out` is 2'b11, `par_err` is 0, `reg_rdata` is 0, and every calendar word holds only its parity bit set (value 1 << (4*PORT_W)).
- R2: Register map. Addresses 0..CAL_WORDS-1 are calendar words. CAL_WORDS is control: bit 0 is the interface enable, bit 1 is the status enable, and bits [PORT_W+1:2] hold the highest legal port. CAL_WORDS+1 is the sequence register: length in [LEN_W-1:0] and repeat count in [LEN_W+REP_W-1:LEN_W]. CAL_WORDS+2 is the ignore mask. A read strobe loads `reg_rdata` at that clock edge. Other addresses read as 0.
- R3: Calendar word k holds slots 4k..4k+3 as PORT_W-bit port numbers, with slot 4k in the lowest field. The top bit is parity. A word is valid when the XOR of all its bits is 1.
- R4: While the interface enable is 1, calendar writes are dropped and calendar reads leave `reg_rdata` unchanged.
- R5: While either enable is 0, `stat_out` is 2'b11 on every cycle.
- R6: A round is one 2'b11 word, then slots 0..L-1 walked M times, then one parity word, and rounds repeat back to back. L and M are the length and repeat count, with 0 read as 1. The first framing word appears on the clock edge after the one that captures the enabling control write.
- R7: Slot encoding is STARVING=2'b00, HUNGRY=2'b01, SATISFIED=2'b10. A port with `fifo_full` set reports SATISFIED. Otherwise a port with `fifo_afull` set reports HUNGRY. Otherwise it reports STARVING. Hints are sampled on the edge that emits the slot.
- R8: A port whose ignore-mask bit is 1 reports STARVING, whatever its hints.
- R9: A slot whose port number exceeds the highest legal port reports SATISFIED. This takes precedence over R8.
- R10: A slot in a calendar word with failing parity reports SATISFIED, ahead of R8 and R9. The first time such a slot is emitted, `par_err` is set, and it stays set until reset.
- R11: The parity word equals the bitwise XOR of all slot words of its round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 17 | Write data |
| reg_rdata | output | 17 | Read data, registered |
| fifo_full | input | 16 | Per-port full hint |
| fifo_afull | input | 16 | Per-port almost-full hint |
| stat_out | output | 2 | Status channel word |
| par_err | output | 1 | Sticky calendar parity error |

## Verification
The bench builds the block with four calendar words (16 slots) and 16 ports. At that size it can sweep the whole calendar, with every port appearing once under a permuted ordering. Every slot outcome is computed arithmetically: hint priority, ignore, out-of-range port and bad parity. Walks are run at full length, at partial length with several repeats, and at zero length and repeat. The parity word is recomputed in the bench for every round. Accesses made while enabled are checked through the register readback.

// File: rtl/rss_pkg.sv
`timescale 1ns/1ps
// Shared types for the status calendar sequencer.
// Assumes: status words are 2 bits; 2'b11 is kept for framing.
package rss_pkg;
    typedef enum logic [1:0] {
        ST_STARVING  = 2'b00,
        ST_HUNGRY    = 2'b01,
        ST_SATISFIED = 2'b10,
        ST_FRAMING   = 2'b11
    } stat_e;

    typedef enum logic [1:0] {
        PH_FRAME = 2'b00,
        PH_SLOT  = 2'b01,
        PH_DIP   = 2'b10
    } phase_e;

    localparam int SLOTS_PER_WORD = 4;
endpackage

// File: rtl/rss_cal_store.sv
`timescale 1ns/1ps
// Calendar storage: CAL_WORDS parity-carrying words with two read ports.
// Writes are dropped while 'locked' is high. Reset loads a word holding
// only its parity bit, which is valid odd parity for an all-zero slot set.
module rss_cal_store #(
    parameter int CAL_WORDS = 32,
    parameter int WORD_W    = 17,
    localparam int IDX_W    = $clog2(CAL_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b
);
    localparam logic [WORD_W-1:0] RESET_WORD = {1'b1, {(WORD_W-1){1'b0}}};

    logic [WORD_W-1:0] mem [CAL_WORDS];

    // Store update: reset fill, otherwise gated single-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CAL_WORDS; i++) mem[i] <= RESET_WORD;
        end else if (wr_en && !locked) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Combinational read ports for the walker and the register path.
    always_comb begin
        word_a = mem[rd_idx_a];
        word_b = mem[rd_idx_b];
    end
endmodule

// File: rtl/rss_slot_eval.sv
`timescale 1ns/1ps
// Slot evaluator: picks one port field out of a calendar word and maps the
// port's hints to a status word. Priority: bad parity, out-of-range port,
// ignore mask, full hint, almost-full hint. Purely combinational.
module rss_slot_eval
    import rss_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int WORD_W   = SLOTS_PER_WORD * PORT_W + 1
) (
    input  logic [WORD_W-1:0]    word,
    input  logic [1:0]           nib,
    input  logic [NUM_PORTS-1:0] full,
    input  logic [NUM_PORTS-1:0] afull,
    input  logic [NUM_PORTS-1:0] ign,
    input  logic [PORT_W-1:0]    port_max,
    output logic [1:0]           status,
    output logic                 bad
);
    logic [PORT_W-1:0] port;

    // Field select, parity check and status priority chain.
    always_comb begin
        port = word[nib*PORT_W +: PORT_W];
        bad  = ~(^word);
        if (bad)                                      status = ST_SATISFIED;
        else if (port > port_max || 32'(port) >= NUM_PORTS) status = ST_SATISFIED;
        else if (ign[port])                           status = ST_STARVING;
        else if (full[port])                          status = ST_SATISFIED;
        else if (afull[port])                         status = ST_HUNGRY;
        else                                          status = ST_STARVING;
    end
endmodule

// File: rtl/rss_walker.sv
`timescale 1ns/1ps
// Round walker: emits framing, LEN slots repeated REP times, then the XOR
// parity of the round. Zero length or repeat is taken as one. Holds the
// framing code and rewinds to a fresh round whenever 'run' is low.
module rss_walker
    import rss_pkg::*;
#(
    parameter int LEN_W = 7,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    input  logic [REP_W-1:0] rep,
    input  logic [1:0]       slot_stat,
    output logic [LEN_W-1:0] slot_idx,
    output logic             in_slot,
    output logic [1:0]       stat
);
    phase_e           phase;
    logic [REP_W-1:0] rep_idx;
    logic [1:0]       acc;
    logic [LEN_W-1:0] eff_len;
    logic [REP_W-1:0] eff_rep;
    logic             last_slot, last_rep;

    // Effective limits and end-of-walk detection.
    always_comb begin
        eff_len   = (len == '0) ? LEN_W'(1) : len;
        eff_rep   = (rep == '0) ? REP_W'(1) : rep;
        last_slot = (slot_idx == eff_len - LEN_W'(1));
        last_rep  = (rep_idx == eff_rep - REP_W'(1));
        in_slot   = (phase == PH_SLOT);
    end

    // Phase sequencing, output word register and round parity accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase    <= PH_FRAME;
            slot_idx <= '0;
            rep_idx  <= '0;
            acc      <= '0;
            stat     <= ST_FRAMING;
        end else begin
            case (phase)
                PH_FRAME: begin
                    stat     <= ST_FRAMING;
                    acc      <= '0;
                    slot_idx <= '0;
                    rep_idx  <= '0;
                    phase    <= PH_SLOT;
                end
                PH_SLOT: begin
                    stat <= slot_stat;
                    acc  <= acc ^ slot_stat;
                    if (last_slot) begin
                        slot_idx <= '0;
                        if (last_rep) phase <= PH_DIP;
                        else          rep_idx <= rep_idx + REP_W'(1);
                    end else begin
                        slot_idx <= slot_idx + LEN_W'(1);
                    end
                end
                PH_DIP: begin
                    stat  <= acc;
                    phase <= PH_FRAME;
                end
                default: phase <= PH_FRAME;
            endcase
        end
    end
endmodule

// File: rtl/rx_stat_seq.sv
`timescale 1ns/1ps
// Receive status calendar sequencer, top level. Holds the configuration
// registers and the registered read path, and joins the calendar store,
// the slot evaluator and the round walker. Assumes the calendar and
// sequence registers are set before the enables are raised; CAL_WORDS >= 2.
module rx_stat_seq
    import rss_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int CAL_WORDS = 32,
    parameter int LEN_W     = 7,
    parameter int REP_W     = 8,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int WORD_W   = SLOTS_PER_WORD * PORT_W + 1,
    localparam int SLOT_W   = $clog2(SLOTS_PER_WORD * CAL_WORDS),
    localparam int IDX_W    = $clog2(CAL_WORDS),
    localparam int ADDR_W   = $clog2(CAL_WORDS + 3),
    localparam int DW0      = (WORD_W > NUM_PORTS) ? WORD_W : NUM_PORTS,
    localparam int DW       = (DW0 > LEN_W + REP_W) ? DW0 : LEN_W + REP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [NUM_PORTS-1:0] fifo_full,
    input  logic [NUM_PORTS-1:0] fifo_afull,
    output logic [1:0]           stat_out,
    output logic                 par_err
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CAL_WORDS);
    localparam logic [ADDR_W-1:0] A_SEQ  = ADDR_W'(CAL_WORDS + 1);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(CAL_WORDS + 2);

    logic                 if_en_q, st_en_q, run;
    logic [PORT_W-1:0]    port_max_q;
    logic [LEN_W-1:0]     len_q;
    logic [REP_W-1:0]     rep_q;
    logic [NUM_PORTS-1:0] ign_q;
    logic                 cal_sel;
    logic [LEN_W-1:0]     slot_idx;
    logic [SLOT_W-1:0]    slot_lin;
    logic [WORD_W-1:0]    walk_word, reg_word;
    logic [1:0]           slot_stat;
    logic                 slot_bad, in_slot;

    // Address decode and walker slot split into word index and field.
    always_comb begin
        cal_sel  = (reg_addr < ADDR_W'(CAL_WORDS));
        run      = if_en_q && st_en_q;
        slot_lin = SLOT_W'(slot_idx);
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_en_q    <= 1'b0;
            st_en_q    <= 1'b0;
            port_max_q <= '0;
            len_q      <= '0;
            rep_q      <= '0;
            ign_q      <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                if_en_q    <= reg_wdata[0];
                st_en_q    <= reg_wdata[1];
                port_max_q <= reg_wdata[PORT_W+1:2];
            end
            if (reg_addr == A_SEQ) begin
                len_q <= reg_wdata[LEN_W-1:0];
                rep_q <= reg_wdata[LEN_W+REP_W-1:LEN_W];
            end
            if (reg_addr == A_MASK) ign_q <= reg_wdata[NUM_PORTS-1:0];
        end
    end

    // Registered read path; calendar reads are frozen while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (cal_sel) begin
                if (!if_en_q) reg_rdata <= DW'(reg_word);
            end else if (reg_addr == A_CTRL) begin
                reg_rdata <= DW'({port_max_q, st_en_q, if_en_q});
            end else if (reg_addr == A_SEQ) begin
                reg_rdata <= DW'({rep_q, len_q});
            end else if (reg_addr == A_MASK) begin
                reg_rdata <= DW'(ign_q);
            end else begin
                reg_rdata <= '0;
            end
        end
    end

    // Sticky parity error, raised when a bad word is walked.
    always_ff @(posedge clk) begin
        if (!rst_n)                           par_err <= 1'b0;
        else if (run && in_slot && slot_bad) par_err <= 1'b1;
    end

    rss_cal_store #(.CAL_WORDS(CAL_WORDS), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (if_en_q),
        .wr_en    (reg_wr && cal_sel),
        .wr_idx   (reg_addr[IDX_W-1:0]),
        .wr_data  (reg_wdata[WORD_W-1:0]),
        .rd_idx_a (slot_lin[SLOT_W-1:2]),
        .rd_idx_b (reg_addr[IDX_W-1:0]),
        .word_a   (walk_word),
        .word_b   (reg_word)
    );

    rss_slot_eval #(.NUM_PORTS(NUM_PORTS)) u_eval (
        .word     (walk_word),
        .nib      (slot_lin[1:0]),
        .full     (fifo_full),
        .afull    (fifo_afull),
        .ign      (ign_q),
        .port_max (port_max_q),
        .status   (slot_stat),
        .bad      (slot_bad)
    );

    rss_walker #(.LEN_W(LEN_W), .REP_W(REP_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .len       (len_q),
        .rep       (rep_q),
        .slot_stat (slot_stat),
        .slot_idx  (slot_idx),
        .in_slot   (in_slot),
        .stat      (stat_out)
    );
endmodule

// File: rtl/rx_stat_seq_chk.sv
`timescale 1ns/1ps
// Property checker for rx_stat_seq, attached with bind below.
// Assumes synchronous active-low reset on the same clock.
module rx_stat_seq_chk #(
    parameter int ADDR_W    = 6,
    parameter int DW        = 17,
    parameter int CAL_WORDS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              in_slot,
    input logic              if_en,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DW-1:0]     reg_rdata,
    input logic [1:0]        stat_out,
    input logic              par_err
);
    assert_idle_framing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> stat_out == 2'b11);

    assert_slot_not_framing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && in_slot) |=> stat_out != 2'b11);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err);

    assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && if_en && reg_addr < ADDR_W'(CAL_WORDS)) |=> $stable(reg_rdata));
endmodule

bind rx_stat_seq rx_stat_seq_chk #(
    .ADDR_W(ADDR_W), .DW(DW), .CAL_WORDS(CAL_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .in_slot(in_slot), .if_en(if_en_q),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .stat_out(stat_out), .par_err(par_err)
);

// File: tb/rx_stat_seq_test.sv
`timescale 1ns/1ps
// Bench: 4 calendar words, 16 ports; whole calendar swept under several
// walk shapes, with every expected word computed arithmetically.
module rx_stat_seq_test;
    localparam int NP = 16;
    localparam int CW = 4;
    localparam int AW = 3;
    localparam int DW = 17;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic [NP-1:0] fifo_full = '0, fifo_afull = '0;
    logic [1:0] stat_out;
    logic par_err;

    int checks = 0, errors = 0;
    logic [3:0]  cal [16];
    bit          bad_w [4];
    logic [15:0] ign;
    int          pmax;

    rx_stat_seq #(.NUM_PORTS(NP), .CAL_WORDS(CW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_full(fifo_full), .fifo_afull(fifo_afull),
        .stat_out(stat_out), .par_err(par_err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input int a);
        @(negedge clk); reg_rd = 1'b1; reg_addr = AW'(a);
        @(negedge clk); reg_rd = 1'b0;
    endtask

    function automatic logic [DW-1:0] pack(input int w, input bit corrupt);
        logic [15:0] d;
        d = {cal[4*w+3], cal[4*w+2], cal[4*w+1], cal[4*w]};
        return {(~^d) ^ corrupt, d};
    endfunction

    function automatic logic [1:0] exp_slot(input int s);
        int p;
        p = int'(cal[s]);
        if (bad_w[s/4])     return 2'b10;
        if (p > pmax)       return 2'b10;
        if (ign[p])         return 2'b00;
        if (fifo_full[p])   return 2'b10;
        if (fifo_afull[p])  return 2'b01;
        return 2'b00;
    endfunction

    function automatic string tag(input int s);
        int p;
        p = int'(cal[s]);
        if (bad_w[s/4]) return "R10 bad-parity slot";
        if (p > pmax)   return "R9 out-of-range port";
        if (ign[p])     return "R8 ignored port";
        return "R7 hint mapping";
    endfunction

    function automatic logic [DW-1:0] ctrl(input bit ie, input bit se);
        return DW'((pmax << 2) | (int'(se) << 1) | int'(ie));
    endfunction

    task automatic rounds(input int len, input int rep, input int n);
        int l, m;
        logic [1:0] acc, e;
        l = (len == 0) ? 1 : len;
        m = (rep == 0) ? 1 : rep;
        wr(CW + 1, DW'((rep << 7) | len));
        wr(CW + 2, DW'(ign));
        wr(CW, ctrl(1, 1));
        for (int r = 0; r < n; r++) begin
            @(posedge clk); #1 chk("R6 framing word", 32'(stat_out), 32'd3);
            acc = 2'b00;
            for (int k = 0; k < m; k++)
                for (int s = 0; s < l; s++) begin
                    e = exp_slot(s);
                    acc ^= e;
                    @(posedge clk); #1 chk(tag(s), 32'(stat_out), 32'(e));
                end
            @(posedge clk); #1 chk("R11 round parity", 32'(stat_out), 32'(acc));
        end
        wr(CW, ctrl(0, 0));
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 16; s++) cal[s] = 4'((s * 7 + 3) % 16);
        for (int w = 0; w < 4; w++) bad_w[w] = 1'b0;
        ign = '0; pmax = 15;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset status", 32'(stat_out), 32'd3);
        chk("R1 reset par_err", 32'(par_err), 32'd0);
        chk("R1 reset rdata", 32'(reg_rdata), 32'd0);
        rd(1);
        chk("R1 reset calendar word", 32'(reg_rdata), 32'h10000);
        repeat (4) begin @(posedge clk); #1 chk("R5 idle framing", 32'(stat_out), 32'd3); end

        // Load calendar and read it back (R3 packing and parity, R2 map).
        for (int w = 0; w < CW; w++) wr(w, pack(w, 1'b0));
        for (int w = 0; w < CW; w++) begin
            rd(w);
            chk("R3 calendar readback", 32'(reg_rdata), 32'(pack(w, 1'b0)));
        end
        wr(CW + 1, DW'((9 << 7) | 13));
        rd(CW + 1);
        chk("R2 sequence register", 32'(reg_rdata), 32'((9 << 7) | 13));
        ign = 16'h0088;
        wr(CW + 2, DW'(ign));
        rd(CW + 2);
        chk("R2 mask register", 32'(reg_rdata), 32'h0088);
        rd(CW + 3);
        chk("R2 unmapped address", 32'(reg_rdata), 32'd0);

        // Interface on, status channel off: framing only; calendar locked.
        wr(CW, ctrl(1, 0));
        rd(CW);
        chk("R2 control register", 32'(reg_rdata), 32'(ctrl(1, 0)));
        repeat (6) begin @(posedge clk); #1 chk("R5 status disabled", 32'(stat_out), 32'd3); end
        wr(0, 17'h1ffff);
        rd(0);
        chk("R4 locked read keeps rdata", 32'(reg_rdata), 32'(ctrl(1, 0)));
        wr(CW, ctrl(0, 0));
        rd(0);
        chk("R4 locked write dropped", 32'(reg_rdata), 32'(pack(0, 1'b0)));

        // Full walk, one repeat, mixed hints (full beats almost-full on port 0).
        fifo_full = 16'h001F; fifo_afull = 16'h03E1;
        rounds(16, 1, 2);

        // Partial walk, three repeats, narrow port range.
        pmax = 9; ign = 16'h0100;
        fifo_full = 16'hA5A5; fifo_afull = 16'h0FF0;
        rounds(5, 3, 2);

        // Zero length and repeat behave as one.
        rounds(0, 0, 3);

        // Corrupt word 2: its slots report SATISFIED and par_err latches.
        pmax = 15; ign = 16'h0000; fifo_full = '0; fifo_afull = 16'hFFFF;
        wr(2, pack(2, 1'b1));
        chk("R10 no error before walk", 32'(par_err), 32'd0);
        bad_w[2] = 1'b1;
        rounds(16, 2, 1);
        chk("R10 error latched", 32'(par_err), 32'd1);
        wr(2, pack(2, 1'b0));
        bad_w[2] = 1'b0;
        rounds(12, 1, 1);
        chk("R10 error sticky", 32'(par_err), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule